// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits on the write side of a parallel NOR flash bus. It sees each write cycle as a single-cycle strobe with an address and a data word. It parses the unlock-prefixed command grammar and keeps track of the current read mode: plain array data, identification codes, or the query table. It also keeps a flag for the security region. When a complete program, chip erase or sector erase sequence arrives, it issues a one-cycle start pulse. The program pulse comes with the target address and data, and the sector erase pulse comes with the sector address. Any write that does not fit the expected step abandons the sequence and returns reads to the array.

A `busy` input from the embedded-algorithm controller tells the decoder when an operation it launched has finished, which is when `busy` falls. While a program or a chip erase is in flight, every write is ignored. While a sector erase is in flight, only the suspend byte is honoured. After the controller drops `busy` in response, the decoder sits in erase-suspend. In that state it accepts a resume, a full program sequence or the identification entry, and it refuses new erases and security entry.

Top module: `nor_cmd_decoder`

## Requirements
- R1: A synchronous active-low reset sets array read mode, clears the security flag and the erase-suspend state, and abandons any partial sequence. All pulse outputs are low after reset.
- R2: A long command opens with data AAh at address 555h and then data 55h at address 2AAh. Only the low 11 address bits are compared, and higher address bits have no effect.
- R3: Outside the security region, a third write of 90h at 555h after the opening pair selects identification read mode (`rd_ident`=1).
- R4: A third write of A0h at 555h arms program. The next write of any address and any data raises `pgm_start` for exactly one cycle, with `pgm_addr` and `pgm_data` holding that write. Data F0h in that fourth write is treated as program data.
- R5: Erase is six writes: the opening pair, 80h at 555h, the opening pair again, and then either 10h at 555h or 30h at any address. 10h pulses `chip_erase_start`. 30h pulses `sector_erase_start`, with `erase_addr` set to that write's address. At most one start pulse is high in any cycle.
- R6: A third write of 88h at 555h sets `sec_region`. The flag survives F0h and mismatching writes, and is cleared only by the opening pair, 90h at 555h, then 00h at any address, or by reset.
- R7: A single write of 98h at address 055h selects query mode, but only from array or identification mode. The same write while in query mode counts as a mismatch and returns array mode.
- R8: Any write whose address or data does not match the expected next step returns array read mode and abandons the sequence.
- R9: Data F0h at any address abandons a partial sequence and returns array read mode, including from identification and query mode.
- R10: From a program or chip erase start until `busy` falls, every write (F0h, B0h, unlock and query included) is ignored. No partial sequence survives the operation.
- R11: During a sector erase, a write of B0h at any address raises `suspend_req` for one cycle. The next fall of `busy` then sets `erase_suspended`. If `busy` falls without a suspend, the erase has completed and the decoder returns to idle.
- R12: While erase-suspended, 30h at any address (with no sequence open) raises `resume_req` for one cycle and clears `erase_suspended`. Program and identification sequences are accepted. Erase (80h) and security entry (88h) third cycles are refused as mismatches. A program run during suspend keeps `erase_suspended` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe of a bus write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data of the write; command byte in bits 7:0 |
| busy | input | 1 | High while the embedded algorithm runs |
| rd_array | output | 1 | Reads return array data |
| rd_ident | output | 1 | Reads return identification codes |
| rd_query | output | 1 | Reads return the query table |
| sec_region | output | 1 | Security region mapped in place of the boot area |
| erase_suspended | output | 1 | A sector erase is suspended |
| pgm_start | output | 1 | One-cycle program launch |
| pgm_addr | output | ADDR_W | Program target address |
| pgm_data | output | DATA_W | Program data |
| chip_erase_start | output | 1 | One-cycle chip erase launch |
| sector_erase_start | output | 1 | One-cycle sector erase launch |
| erase_addr | output | ADDR_W | Address naming the sector to erase |
| suspend_req | output | 1 | One-cycle erase suspend request |
| resume_req | output | 1 | One-cycle erase resume request |

## Verification
Every mode flag and every pulse changes on the clock edge that samples the write completing its sequence. The bench drives a write at a falling edge and reads the result at the next falling edge, and checks that pulses are low one cycle later. A fall of `busy` takes effect at the first rising edge that sees it low, so suspend and completion states are read one falling edge after `busy` is dropped. Sweeps cover all 256 third-cycle bytes, address-bit flips in the second unlock cycle, and varied high address bits, with the expected mode computed in the bench.

// File: rtl/nfd_pkg.sv
// Shared constants and types for the NOR command decoder.
// Assumes the command byte sits in data bits 7:0.
package nfd_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_OPEN_A   = 8'hAA;
    localparam logic [CMD_W-1:0] CMD_OPEN_B   = 8'h55;
    localparam logic [CMD_W-1:0] CMD_IDENT    = 8'h90;
    localparam logic [CMD_W-1:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [CMD_W-1:0] CMD_ERASE    = 8'h80;
    localparam logic [CMD_W-1:0] CMD_CHIP     = 8'h10;
    localparam logic [CMD_W-1:0] CMD_SECTOR   = 8'h30;
    localparam logic [CMD_W-1:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [CMD_W-1:0] CMD_SECURE   = 8'h88;
    localparam logic [CMD_W-1:0] CMD_QUERY    = 8'h98;
    localparam logic [CMD_W-1:0] CMD_RESET    = 8'hF0;
    localparam logic [CMD_W-1:0] CMD_SEC_EXIT = 8'h00;

    localparam logic [15:0] ADR_FIRST  = 16'h0555;
    localparam logic [15:0] ADR_SECOND = 16'h02AA;
    localparam logic [15:0] ADR_QUERY  = 16'h0055;

    // Position inside a multi-cycle command
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_OPEN1,
        SQ_OPEN2,
        SQ_PGM_ARM,
        SQ_ER_ARM,
        SQ_ER_OPEN1,
        SQ_ER_OPEN2,
        SQ_SEC_EXIT
    } seq_t;

    // What a read returns
    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_IDENT,
        RM_QUERY
    } rmode_t;

    // Embedded operation in flight
    typedef enum logic [2:0] {
        OP_NONE,
        OP_PGM,
        OP_CHIP,
        OP_SECT,
        OP_SUSP,
        OP_SUSP_PGM
    } op_t;

    // Decoded view of one write
    typedef struct packed {
        logic              at_first;
        logic              at_second;
        logic              at_query;
        logic [CMD_W-1:0]  cmd;
    } wr_class_t;

endpackage

// File: rtl/nfd_wr_classify.sv
// Classifies one bus write: which command address it hits (low CMP_W bits
// only) and which command byte it carries. Purely combinational.
module nfd_wr_classify
    import nfd_pkg::*;
#(
    parameter int CMP_W = 11
) (
    input  logic [CMP_W-1:0] cmp_addr,
    input  logic [CMD_W-1:0] cmd_byte,
    output wr_class_t        cls
);

    localparam logic [CMP_W-1:0] A_FIRST  = ADR_FIRST[CMP_W-1:0];
    localparam logic [CMP_W-1:0] A_SECOND = ADR_SECOND[CMP_W-1:0];
    localparam logic [CMP_W-1:0] A_QUERY  = ADR_QUERY[CMP_W-1:0];

    // Address match flags and command byte pass-through
    always_comb begin
        cls.at_first  = (cmp_addr == A_FIRST);
        cls.at_second = (cmp_addr == A_SECOND);
        cls.at_query  = (cmp_addr == A_QUERY);
        cls.cmd       = cmd_byte;
    end

endmodule

// File: rtl/nfd_seq_fsm.sv
// Command grammar state machine. It walks the unlock-prefixed sequences,
// owns the read mode and the security flag, and issues registered start
// pulses with latched operands. It assumes cmd_open is low while an embedded
// operation blocks commands, and that resume_take marks a write consumed
// by the operation tracker.
module nfd_seq_fsm
    import nfd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  wr_class_t         cls,
    input  logic              cmd_open,
    input  logic              in_suspend,
    input  logic              resume_take,
    output logic              seq_idle,
    output rmode_t            rmode,
    output logic              sec_on,
    output logic              pgm_start,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              chip_start,
    output logic              sect_start,
    output logic [ADDR_W-1:0] sect_addr
);

    seq_t   seq, seq_n;
    rmode_t rm_n;
    logic   sec_n, pgm_n, chip_n, sect_n;
    logic   take;

    assign take     = wr_en && cmd_open && !resume_take;
    assign seq_idle = (seq == SQ_IDLE);

    // Next state: match the expected step, otherwise fall back to array read
    always_comb begin
        seq_n  = seq;
        rm_n   = rmode;
        sec_n  = sec_on;
        pgm_n  = 1'b0;
        chip_n = 1'b0;
        sect_n = 1'b0;
        if (take) begin
            if (seq != SQ_PGM_ARM && cls.cmd == CMD_RESET) begin
                seq_n = SQ_IDLE;
                rm_n  = RM_ARRAY;
            end else begin
                seq_n = SQ_IDLE;
                rm_n  = RM_ARRAY;
                case (seq)
                    SQ_IDLE: begin
                        if (cls.at_first && cls.cmd == CMD_OPEN_A) begin
                            seq_n = SQ_OPEN1;
                            rm_n  = rmode;
                        end else if (cls.at_query && cls.cmd == CMD_QUERY &&
                                     rmode != RM_QUERY) begin
                            rm_n = RM_QUERY;
                        end
                    end
                    SQ_OPEN1: begin
                        if (cls.at_second && cls.cmd == CMD_OPEN_B) begin
                            seq_n = SQ_OPEN2;
                            rm_n  = rmode;
                        end
                    end
                    SQ_OPEN2: begin
                        if (cls.at_first) begin
                            case (cls.cmd)
                                CMD_IDENT: begin
                                    if (sec_on) begin
                                        seq_n = SQ_SEC_EXIT;
                                        rm_n  = rmode;
                                    end else begin
                                        rm_n = RM_IDENT;
                                    end
                                end
                                CMD_PROGRAM: seq_n = SQ_PGM_ARM;
                                CMD_ERASE: begin
                                    if (!in_suspend) seq_n = SQ_ER_ARM;
                                end
                                CMD_SECURE: begin
                                    if (!in_suspend) sec_n = 1'b1;
                                end
                                default: ;
                            endcase
                        end
                    end
                    SQ_PGM_ARM: pgm_n = 1'b1;
                    SQ_ER_ARM: begin
                        if (cls.at_first && cls.cmd == CMD_OPEN_A) seq_n = SQ_ER_OPEN1;
                    end
                    SQ_ER_OPEN1: begin
                        if (cls.at_second && cls.cmd == CMD_OPEN_B) seq_n = SQ_ER_OPEN2;
                    end
                    SQ_ER_OPEN2: begin
                        if (cls.at_first && cls.cmd == CMD_CHIP) chip_n = 1'b1;
                        else if (cls.cmd == CMD_SECTOR)           sect_n = 1'b1;
                    end
                    SQ_SEC_EXIT: begin
                        if (cls.cmd == CMD_SEC_EXIT) sec_n = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // State, mode and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq        <= SQ_IDLE;
            rmode      <= RM_ARRAY;
            sec_on     <= 1'b0;
            pgm_start  <= 1'b0;
            chip_start <= 1'b0;
            sect_start <= 1'b0;
        end else begin
            seq        <= seq_n;
            rmode      <= rm_n;
            sec_on     <= sec_n;
            pgm_start  <= pgm_n;
            chip_start <= chip_n;
            sect_start <= sect_n;
        end
    end

    // Operand latches, loaded only when a start is issued
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pgm_addr  <= '0;
            pgm_data  <= '0;
            sect_addr <= '0;
        end else begin
            if (pgm_n) begin
                pgm_addr <= wr_addr;
                pgm_data <= wr_data;
            end
            if (sect_n) sect_addr <= wr_addr;
        end
    end

    assert_sec_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_on) |-> $past(wr_en) && $past(wr_data[7:0]) == 8'h88);

    assert_sec_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sec_on) |-> $past(wr_en) && $past(wr_data[7:0]) == 8'h00);

    assert_one_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_start, chip_start, sect_start}));

    assert_pgm_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_start |=> !pgm_start);

endmodule

// File: rtl/nfd_op_track.sv
// Tracks the embedded operation launched by the grammar FSM. It closes the
// command path while an operation runs, lets only suspend through during
// sector erase, and handles suspend/resume. It assumes busy rises the cycle
// after a start or a resume and falls once when the operation ends or parks.
module nfd_op_track
    import nfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] cmd,
    input  logic             busy,
    input  logic             seq_idle,
    input  logic             pgm_start,
    input  logic             chip_start,
    input  logic             sect_start,
    output logic             cmd_open,
    output logic             resume_take,
    output logic             suspend_req,
    output logic             resume_req,
    output logic             erase_suspended
);

    op_t  op;
    logic busy_q;
    logic susp_pend;
    logic busy_fell;
    logic suspend_take;

    // Command path gating and suspend/resume recognition
    always_comb begin
        busy_fell    = busy_q && !busy;
        cmd_open     = (op == OP_NONE || op == OP_SUSP) &&
                       !(pgm_start || chip_start || sect_start);
        resume_take  = wr_en && op == OP_SUSP && seq_idle && cmd == CMD_SECTOR;
        suspend_take = wr_en && op == OP_SECT && !susp_pend && cmd == CMD_SUSPEND;
    end

    assign erase_suspended = (op == OP_SUSP) || (op == OP_SUSP_PGM);

    // Operation state, busy edge detect and request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op          <= OP_NONE;
            busy_q      <= 1'b0;
            susp_pend   <= 1'b0;
            suspend_req <= 1'b0;
            resume_req  <= 1'b0;
        end else begin
            busy_q      <= busy;
            suspend_req <= suspend_take;
            resume_req  <= resume_take;
            case (op)
                OP_NONE: begin
                    if (pgm_start)       op <= OP_PGM;
                    else if (chip_start) op <= OP_CHIP;
                    else if (sect_start) op <= OP_SECT;
                end
                OP_PGM, OP_CHIP: begin
                    if (busy_fell) op <= OP_NONE;
                end
                OP_SECT: begin
                    if (busy_fell) begin
                        op        <= susp_pend ? OP_SUSP : OP_NONE;
                        susp_pend <= 1'b0;
                    end else if (suspend_take) begin
                        susp_pend <= 1'b1;
                    end
                end
                OP_SUSP: begin
                    if (resume_take)    op <= OP_SECT;
                    else if (pgm_start) op <= OP_SUSP_PGM;
                end
                OP_SUSP_PGM: begin
                    if (busy_fell) op <= OP_SUSP;
                end
                default: op <= OP_NONE;
            endcase
        end
    end

    assert_suspend_on_busy_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_suspended) |-> !$past(busy));

    assert_resume_leaves_suspend_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> !erase_suspended && $past(erase_suspended));

endmodule

// File: rtl/nor_cmd_decoder.sv
// Top of the NOR flash command decoder. It wires the write classifier, the
// grammar FSM and the operation tracker together. Writes are single-cycle
// strobes synchronous to clk; all outputs are registered.
module nor_cmd_decoder
    import nfd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16,
    parameter int CMP_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              rd_array,
    output logic              rd_ident,
    output logic              rd_query,
    output logic              sec_region,
    output logic              erase_suspended,
    output logic              pgm_start,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              chip_erase_start,
    output logic              sector_erase_start,
    output logic [ADDR_W-1:0] erase_addr,
    output logic              suspend_req,
    output logic              resume_req
);

    wr_class_t cls;
    rmode_t    rmode;
    logic      cmd_open;
    logic      resume_take;
    logic      seq_idle;

    nfd_wr_classify #(.CMP_W(CMP_W)) u_classify (
        .cmp_addr (wr_addr[CMP_W-1:0]),
        .cmd_byte (wr_data[CMD_W-1:0]),
        .cls      (cls)
    );

    nfd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cls         (cls),
        .cmd_open    (cmd_open),
        .in_suspend  (erase_suspended),
        .resume_take (resume_take),
        .seq_idle    (seq_idle),
        .rmode       (rmode),
        .sec_on      (sec_region),
        .pgm_start   (pgm_start),
        .pgm_addr    (pgm_addr),
        .pgm_data    (pgm_data),
        .chip_start  (chip_erase_start),
        .sect_start  (sector_erase_start),
        .sect_addr   (erase_addr)
    );

    nfd_op_track u_op (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .cmd             (wr_data[CMD_W-1:0]),
        .busy            (busy),
        .seq_idle        (seq_idle),
        .pgm_start       (pgm_start),
        .chip_start      (chip_erase_start),
        .sect_start      (sector_erase_start),
        .cmd_open        (cmd_open),
        .resume_take     (resume_take),
        .suspend_req     (suspend_req),
        .resume_req      (resume_req),
        .erase_suspended (erase_suspended)
    );

    // Read-mode decode to one flag per mode
    always_comb begin
        rd_array = (rmode == RM_ARRAY);
        rd_ident = (rmode == RM_IDENT);
        rd_query = (rmode == RM_QUERY);
    end

    assert_no_start_while_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_open |=> !(pgm_start || chip_erase_start || sector_erase_start));

    assert_query_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_query) |-> $past(wr_en) && $past(wr_data[7:0]) == 8'h98);

endmodule

// File: tb/tb_nor_cmd_decoder.sv
`timescale 1ns/1ps
module tb_nor_cmd_decoder;

    localparam int AW = 21;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy = 1'b0;
    logic          rd_array, rd_ident, rd_query, sec_region, erase_suspended;
    logic          pgm_start, chip_erase_start, sector_erase_start;
    logic          suspend_req, resume_req;
    logic [AW-1:0] pgm_addr, erase_addr;
    logic [DW-1:0] pgm_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    nor_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .rd_array(rd_array),
        .rd_ident(rd_ident), .rd_query(rd_query), .sec_region(sec_region),
        .erase_suspended(erase_suspended), .pgm_start(pgm_start),
        .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .chip_erase_start(chip_erase_start),
        .sector_erase_start(sector_erase_start), .erase_addr(erase_addr),
        .suspend_req(suspend_req), .resume_req(resume_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one write: driven at a falling edge, result visible at the next one
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_pair(input logic [AW-1:0] hi);
        wr(hi | 21'h555, 16'h00AA);
        wr(hi | 21'h2AA, 16'h0055);
    endtask

    // run an operation to completion on the busy line
    task automatic run_busy();
        busy = 1'b1; idle(3); busy = 1'b0; idle(2);
    endtask

    function automatic logic [2:0] mode();
        return {rd_query, rd_ident, rd_array};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 mode after reset", mode(), 3'b001);
        chk("R1 sec after reset", sec_region, 0);
        chk("R1 susp after reset", erase_suspended, 0);
        chk("R1 pulses after reset",
            {pgm_start, chip_erase_start, sector_erase_start, suspend_req, resume_req}, 0);

        // R3 / R8 / R9 / R4 / R6: sweep every third-cycle byte
        for (int d = 0; d < 256; d++) begin
            wr(21'h0, 16'h00F0);
            open_pair(21'h0);
            wr(21'h555, 16'(d));
            chk("R3 sweep ident", rd_ident, (d == 8'h90));
            chk("R6 sweep sec", sec_region, (d == 8'h88));
            wr(21'h123, 16'h00F0);
            chk("R4 sweep pgm on F0 data", pgm_start, (d == 8'hA0));
            if (d == 8'hA0) run_busy();
            if (d == 8'h88) begin
                open_pair(21'h0); wr(21'h555, 16'h0090); wr(21'h7, 16'h0000);
                chk("R6 sweep exit", sec_region, 0);
            end
        end

        // R2 high address bits are don't-care
        for (int u = 0; u < 1024; u += 97) begin
            logic [AW-1:0] hi = AW'(u) << 11;
            open_pair(hi);
            wr(hi | 21'h555, 16'h0090);
            chk("R2 high bits ignored", rd_ident, 1);
            wr(21'h0, 16'h00F0);
            chk("R9 F0 from ident", mode(), 3'b001);
        end
        // R2 / R8 any low-bit mismatch in the second cycle aborts
        for (int b = 0; b < 11; b++) begin
            wr(21'h555, 16'h00AA);
            wr(21'h2AA ^ (21'h1 << b), 16'h0055);
            wr(21'h555, 16'h0090);
            chk("R2 low bit mismatch", rd_ident, 0);
        end

        // R9 F0 between cycles
        wr(21'h555, 16'h00AA);
        wr(21'h1999, 16'h00F0);
        wr(21'h2AA, 16'h0055);
        wr(21'h555, 16'h0090);
        chk("R9 F0 abandons sequence", rd_ident, 0);

        // R7 query entry rules
        wr(21'h055, 16'h0098);
        chk("R7 query from array", mode(), 3'b100);
        wr(21'h055, 16'h0098);
        chk("R7 query from query -> array", mode(), 3'b001);
        open_pair(21'h0); wr(21'h555, 16'h0090);
        wr(21'h8055, 16'h0098);
        chk("R7 query from ident", mode(), 3'b100);
        wr(21'h3, 16'h00F0);
        chk("R9 F0 from query", mode(), 3'b001);
        wr(21'h455, 16'h0098);
        chk("R7 query address mismatch", mode(), 3'b001);
        // R8 mismatch from ident
        open_pair(21'h0); wr(21'h555, 16'h0090);
        wr(21'h0, 16'h0012);
        chk("R8 mismatch leaves ident", mode(), 3'b001);

        // R4 program
        open_pair(21'h0); wr(21'h555, 16'h00A0);
        wr(21'h1ABCDE, 16'hBEEF);
        chk("R4 pgm pulse", pgm_start, 1);
        chk("R4 pgm addr", pgm_addr, 21'h1ABCDE);
        chk("R4 pgm data", pgm_data, 16'hBEEF);
        busy = 1'b1;
        idle(1);
        chk("R4 pgm one cycle", pgm_start, 0);
        // R10 writes ignored while programming
        open_pair(21'h0); wr(21'h555, 16'h0090);
        chk("R10 ident ignored", rd_ident, 0);
        wr(21'h055, 16'h0098);
        chk("R10 query ignored", rd_query, 0);
        wr(21'h0, 16'h00B0);
        chk("R10 suspend ignored in pgm", suspend_req, 0);
        open_pair(21'h0);
        busy = 1'b0; idle(2);
        wr(21'h555, 16'h0090);
        chk("R10 no partial sequence kept", rd_ident, 0);

        // R5 chip erase
        open_pair(21'h0); wr(21'h555, 16'h0080);
        open_pair(21'h0); wr(21'h555, 16'h0010);
        chk("R5 chip pulse", {chip_erase_start, sector_erase_start, pgm_start}, 3'b100);
        busy = 1'b1; idle(1);
        wr(21'h0, 16'h00B0);
        chk("R10 suspend ignored in chip erase", suspend_req, 0);
        busy = 1'b0; idle(2);
        chk("R10 no suspend after chip erase", erase_suspended, 0);

        // R5 / R11 sector erase with suspend
        open_pair(21'h0); wr(21'h555, 16'h0080);
        open_pair(21'h0); wr(21'h0F8123, 16'h0030);
        chk("R5 sector pulse", {chip_erase_start, sector_erase_start}, 2'b01);
        chk("R5 sector addr", erase_addr, 21'h0F8123);
        busy = 1'b1; idle(2);
        wr(21'h555, 16'h0090);
        wr(21'h42, 16'h00B0);
        chk("R11 suspend pulse", suspend_req, 1);
        busy = 1'b0; idle(1);
        chk("R11 suspended", erase_suspended, 1);
        // R12 inside suspend
        open_pair(21'h0); wr(21'h555, 16'h0090);
        chk("R12 ident in suspend", rd_ident, 1);
        wr(21'h0, 16'h00F0);
        open_pair(21'h0); wr(21'h555, 16'h0080);
        open_pair(21'h0); wr(21'h555, 16'h0010);
        chk("R12 erase refused in suspend", chip_erase_start, 0);
        open_pair(21'h0); wr(21'h555, 16'h0088);
        chk("R12 security refused in suspend", sec_region, 0);
        open_pair(21'h0); wr(21'h555, 16'h00A0);
        wr(21'h100, 16'h1234);
        chk("R12 program in suspend", pgm_start, 1);
        run_busy();
        chk("R12 still suspended after program", erase_suspended, 1);
        wr(21'h9, 16'h0030);
        chk("R12 resume pulse", resume_req, 1);
        chk("R12 resume clears suspend", erase_suspended, 0);
        run_busy();
        chk("R11 erase completes to idle", erase_suspended, 0);
        open_pair(21'h0); wr(21'h555, 16'h0090);
        chk("R11 commands accepted after erase", rd_ident, 1);
        wr(21'h0, 16'h00F0);

        // R6 security persistence and exit
        open_pair(21'h0); wr(21'h555, 16'h0088);
        chk("R6 enter", sec_region, 1);
        wr(21'h0, 16'h00F0);
        wr(21'h0, 16'h0012);
        chk("R6 survives F0 and mismatch", sec_region, 1);
        open_pair(21'h0); wr(21'h555, 16'h0090);
        chk("R6 no ident in region", rd_ident, 0);
        wr(21'h0, 16'h005A);
        chk("R6 bad exit keeps region", sec_region, 1);
        open_pair(21'h0); wr(21'h555, 16'h0090); wr(21'h1F00, 16'h0000);
        chk("R6 exit", sec_region, 0);

        // R1 reset mid-sequence and in security region
        open_pair(21'h0); wr(21'h555, 16'h0088);
        open_pair(21'h0);
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        chk("R1 reset clears sec", sec_region, 0);
        wr(21'h555, 16'h0090);
        chk("R1 reset abandons sequence", rd_ident, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule